// File: doc/BRIEF.md
# Split-Tree Priority Selector

This block picks one word from N data inputs. Each input has its own condition bit. The output is the word of the asserted condition with the smallest index. The conditions may overlap, so any number of them can be set in the same cycle. When no condition is set, the output is a default word given by a parameter, and a hit flag goes low.

A plain if/else chain would give a path N conditions deep. To avoid that, the inputs are cut into leaves of a few inputs each. Each leaf resolves its own priority. The leaf results are then merged pairwise in a balanced binary tree. At every merge the lower-index half wins whenever any of its conditions is set. Otherwise the upper half's result passes through. The logic depth therefore grows with the leaf size plus log2(N/leaf) instead of with N. A parameter selects whether the result is registered before it reaches the ports.

Top module: `split_prio_mux`

## Requirements
- R1: The selected word equals the data word of the lowest-index asserted condition. Condition bit `i` pairs with data bits `[i*DW +: DW]`.
- R2: Index 0 has the highest priority. Changing the data of any input above the winning index leaves the output unchanged.
- R3: When no condition bit is set, the selected word equals `DEFAULT_VAL`.
- R4: `hit_o` is 1 exactly when at least one condition bit is set.
- R5: When any condition in the lower half of the inputs is set, the result comes from the lower half, whatever the upper half holds. Otherwise it is the upper half's own priority result.
- R6: With `OUT_REG=1`, the outputs follow the inputs one clock later and hold until the next rising edge. With `OUT_REG=0`, they follow in the same cycle.
- R7: With `OUT_REG=1`, while `rst_n` is low the outputs read `DEFAULT_VAL` with `hit_o` at 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| cond_i | input | N_IN | Condition bits; bit 0 has the highest priority |
| data_i | input | N_IN*DW | Data words packed side by side; word i at bits [i*DW +: DW] |
| hit_o | output | 1 | Set when any condition bit is set |
| sel_o | output | DW | Selected word, or DEFAULT_VAL when no condition is set |

## Verification
The bench builds two copies of the block side by side.

The first uses 64 inputs, 16-bit words, leaves of 4 and a registered output. It reaches a four-level merge tree, the reset value and the one-cycle latency.

The second uses 8 inputs, 8-bit words, leaves of 2 and no register. It checks the same priority rules with no latency, and shows that the result does not depend on the leaf size chosen.

Both are fed the same condition patterns: dense, sparse and single-bit. These include the patterns that straddle the half boundary, where the lower-half-wins rule decides the result.

// File: rtl/pmux_pkg.sv
package pmux_pkg;

   // True when v is a nonzero power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pmux_leaf.sv
// Linear priority over a small group: the lowest set index wins.
module pmux_leaf #(
   parameter int W  = 4,
   parameter int DW = 16
) (
   input  logic [W-1:0]    c_i,
   input  logic [W*DW-1:0] d_i,
   output logic            v_o,
   output logic [DW-1:0]   q_o
);

   always_comb begin
      v_o = 1'b0;
      q_o = '0;
      // Scan from the top down, so a lower index overwrites a higher one.
      for (int i = W - 1; i >= 0; i--) begin
         if (c_i[i]) begin
            v_o = 1'b1;
            q_o = d_i[i*DW +: DW];
         end
      end
   end

endmodule

// File: rtl/pmux_merge.sv
// Two-way merge node: the lower-index side wins when it has any hit.
module pmux_merge #(
   parameter int DW = 16
) (
   input  logic          lo_v_i,
   input  logic [DW-1:0] lo_q_i,
   input  logic          hi_v_i,
   input  logic [DW-1:0] hi_q_i,
   output logic          v_o,
   output logic [DW-1:0] q_o
);

   assign v_o = lo_v_i | hi_v_i;
   assign q_o = lo_v_i ? lo_q_i : hi_q_i;

endmodule

// File: rtl/pmux_tree.sv
// Leaves of LEAF inputs feed a balanced merge tree. Nodes are numbered as
// a heap: node 1 is the root, node n has children 2n (lower half) and
// 2n+1 (upper half), and the leaves are nodes NLEAF .. 2*NLEAF-1.
module pmux_tree #(
   parameter int N    = 64,
   parameter int LEAF = 4,
   parameter int DW   = 16
) (
   input  logic [N-1:0]    cond_i,
   input  logic [N*DW-1:0] data_i,
   output logic            v_o,
   output logic [DW-1:0]   q_o
);

   localparam int NLEAF = N / LEAF;
   localparam int NODES = 2 * NLEAF - 1;

   logic          hv [1:NODES];
   logic [DW-1:0] hq [1:NODES];

   for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
      pmux_leaf #(.W(LEAF), .DW(DW)) u_leaf (
         .c_i (cond_i[k*LEAF +: LEAF]),
         .d_i (data_i[k*LEAF*DW +: LEAF*DW]),
         .v_o (hv[NLEAF + k]),
         .q_o (hq[NLEAF + k])
      );
   end

   for (genvar n = 1; n < NLEAF; n++) begin : g_node
      pmux_merge #(.DW(DW)) u_merge (
         .lo_v_i (hv[2*n]),
         .lo_q_i (hq[2*n]),
         .hi_v_i (hv[2*n + 1]),
         .hi_q_i (hq[2*n + 1]),
         .v_o    (hv[n]),
         .q_o    (hq[n])
      );
   end

   assign v_o = hv[1];
   assign q_o = hq[1];

endmodule

// File: rtl/pmux_outreg.sv
// Optional output stage: a register when EN=1, plain wires otherwise.
module pmux_outreg #(
   parameter int              DW      = 16,
   parameter bit              EN      = 1'b1,
   parameter logic [DW-1:0]   RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_i,
   input  logic [DW-1:0] q_i,
   output logic          v_o,
   output logic [DW-1:0] q_o
);

   if (EN) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_o <= 1'b0;
            q_o <= RST_VAL;
         end else begin
            v_o <= v_i;
            q_o <= q_i;
         end
      end
   end else begin : g_wire
      assign v_o = v_i;
      assign q_o = q_i;
   end

endmodule

// File: rtl/split_prio_mux.sv
module split_prio_mux #(
   parameter int            N_IN        = 64,
   parameter int            DW          = 16,
   parameter int            LEAF        = 4,
   parameter bit            OUT_REG     = 1'b1,
   parameter logic [DW-1:0] DEFAULT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   cond_i,
   input  logic [N_IN*DW-1:0] data_i,
   output logic              hit_o,
   output logic [DW-1:0]     sel_o
);

   // Elaboration-time parameter checks.
   if (!pmux_pkg::is_pow2(N_IN) || N_IN < 2) begin : g_bad_n
      $error("split_prio_mux: N_IN must be a power of two of at least 2");
   end
   if (!pmux_pkg::is_pow2(LEAF) || LEAF > N_IN) begin : g_bad_leaf
      $error("split_prio_mux: LEAF must be a power of two no larger than N_IN");
   end
   if (DW < 1) begin : g_bad_dw
      $error("split_prio_mux: DW must be at least 1");
   end

   logic          root_v;
   logic [DW-1:0] root_q;
   logic [DW-1:0] comb_q;

   pmux_tree #(.N(N_IN), .LEAF(LEAF), .DW(DW)) u_tree (
      .cond_i (cond_i),
      .data_i (data_i),
      .v_o    (root_v),
      .q_o    (root_q)
   );

   assign comb_q = root_v ? root_q : DEFAULT_VAL;

   pmux_outreg #(.DW(DW), .EN(OUT_REG), .RST_VAL(DEFAULT_VAL)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (root_v),
      .q_i   (comb_q),
      .v_o   (hit_o),
      .q_o   (sel_o)
   );

endmodule

// File: rtl/split_prio_mux_chk.sv
// Checker: compares the ports against a linear reference scan.
module split_prio_mux_chk #(
   parameter int            N_IN        = 64,
   parameter int            DW          = 16,
   parameter bit            OUT_REG     = 1'b1,
   parameter logic [DW-1:0] DEFAULT_VAL = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_IN-1:0]    cond_i,
   input logic [N_IN*DW-1:0] data_i,
   input logic               hit_o,
   input logic [DW-1:0]      sel_o
);

   localparam int HALF = N_IN / 2;

   logic          ref_v, lo_v;
   logic [DW-1:0] ref_q, lo_q;
   logic          c0;
   logic [DW-1:0] d0;

   always_comb begin
      ref_v = 1'b0;
      ref_q = DEFAULT_VAL;
      lo_v  = 1'b0;
      lo_q  = DEFAULT_VAL;
      for (int i = 0; i < N_IN; i++) begin
         if (cond_i[i] && !ref_v) begin
            ref_v = 1'b1;
            ref_q = data_i[i*DW +: DW];
         end
      end
      for (int i = 0; i < HALF; i++) begin
         if (cond_i[i] && !lo_v) begin
            lo_v = 1'b1;
            lo_q = data_i[i*DW +: DW];
         end
      end
   end

   assign c0 = cond_i[0];
   assign d0 = data_i[DW-1:0];

   logic          e_v, e_lo_v, e_c0;
   logic [DW-1:0] e_q, e_lo_q, e_d0;

   if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_v <= 1'b0; e_q <= DEFAULT_VAL;
            e_lo_v <= 1'b0; e_lo_q <= DEFAULT_VAL;
            e_c0 <= 1'b0; e_d0 <= '0;
         end else begin
            e_v <= ref_v; e_q <= ref_q;
            e_lo_v <= lo_v; e_lo_q <= lo_q;
            e_c0 <= c0; e_d0 <= d0;
         end
      end
   end else begin : g_now
      assign e_v = ref_v;  assign e_q = ref_q;
      assign e_lo_v = lo_v; assign e_lo_q = lo_q;
      assign e_c0 = c0;    assign e_d0 = d0;
   end

   AST_MATCH_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o == e_q); // R1
   AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      e_c0 |-> sel_o == e_d0); // R2
   AST_IDLE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> sel_o == DEFAULT_VAL); // R3
   AST_HIT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o == e_v); // R4
   AST_LOWER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      e_lo_v |-> (sel_o == e_lo_q && hit_o)); // R5

endmodule

bind split_prio_mux split_prio_mux_chk #(
   .N_IN(N_IN), .DW(DW), .OUT_REG(OUT_REG), .DEFAULT_VAL(DEFAULT_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .data_i(data_i),
   .hit_o(hit_o), .sel_o(sel_o)
);

// File: tb/split_prio_mux_test.sv
module split_prio_mux_test;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 64, DWA = 16;
   localparam int NB = 8,  DWB = 8;
   localparam logic [DWA-1:0] DEF_A = 16'hDEAD;
   localparam logic [DWB-1:0] DEF_B = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NA-1:0]     ca = '0;
   logic [NA*DWA-1:0] da = '0;
   logic [NB-1:0]     cb = '0;
   logic [NB*DWB-1:0] db = '0;
   logic              hit_a, hit_b;
   logic [DWA-1:0]    sel_a;
   logic [DWB-1:0]    sel_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DWA:0] prev_a;

   always #(CLK_PERIOD/2) clk = ~clk;

   split_prio_mux #(.N_IN(NA), .DW(DWA), .LEAF(4), .OUT_REG(1'b1),
                    .DEFAULT_VAL(DEF_A)) uut (
      .clk(clk), .rst_n(rst_n), .cond_i(ca), .data_i(da),
      .hit_o(hit_a), .sel_o(sel_a));

   split_prio_mux #(.N_IN(NB), .DW(DWB), .LEAF(2), .OUT_REG(1'b0),
                    .DEFAULT_VAL(DEF_B)) uut_b (
      .clk(clk), .rst_n(rst_n), .cond_i(cb), .data_i(db),
      .hit_o(hit_b), .sel_o(sel_b));

   // Linear reference: {hit, word}.
   function automatic logic [DWA:0] ref_a(logic [NA-1:0] c, logic [NA*DWA-1:0] d);
      for (int i = 0; i < NA; i++) if (c[i]) return {1'b1, d[i*DWA +: DWA]};
      return {1'b0, DEF_A};
   endfunction

   function automatic logic [DWB:0] ref_b(logic [NB-1:0] c, logic [NB*DWB-1:0] d);
      for (int i = 0; i < NB; i++) if (c[i]) return {1'b1, d[i*DWB +: DWB]};
      return {1'b0, DEF_B};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill_data();
      for (int w = 0; w < NA; w++) da[w*DWA +: DWA] = DWA'($urandom);
      for (int w = 0; w < NB; w++) db[w*DWB +: DWB] = DWB'($urandom);
   endtask

   // Drive at a falling edge, check the unregistered copy at once, the
   // registered copy still on the old value (R6), then after the edge.
   task automatic apply(logic [NA-1:0] c, string req);
      logic [DWA:0] ea;
      logic [DWB:0] eb;
      ca = c;
      cb = c[NB-1:0];
      fill_data();
      ea = ref_a(ca, da);
      eb = ref_b(cb, db);
      #1;
      chk({req, " sel B"}, 32'(sel_b), 32'(eb[DWB-1:0]));
      chk("R4 hit B", 32'(hit_b), 32'(eb[DWB]));
      chk("R6 A holds before edge", 32'(sel_a), 32'(prev_a[DWA-1:0]));
      @(posedge clk);
      #1;
      chk({req, " sel A"}, 32'(sel_a), 32'(ea[DWA-1:0]));
      chk("R4 hit A", 32'(hit_a), 32'(ea[DWA]));
      prev_a = ea;
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R6 actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [DWA-1:0] held;
      void'($urandom(32'h1F2E3D4C));
      // R7: reset holds the registered copy at its default.
      ca = '1;
      fill_data();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 sel during reset", 32'(sel_a), 32'(DEF_A));
      chk("R7 hit during reset", 32'(hit_a), 32'd0);
      rst_n = 1'b1;
      prev_a = {1'b0, DEF_A};
      @(negedge clk);
      prev_a = ref_a(ca, da);

      apply('0, "R3");
      apply('1, "R2");
      apply(64'h8000_0000_0000_0000, "R1");
      apply(64'h0000_0001_8000_0000, "R5");
      apply(64'h0000_0101_0000_0000, "R5");
      apply(64'hFFFF_FFFF_0000_0004, "R5");
      apply(64'h0000_0000_0000_0080, "R1");

      // R2: winner at index 5; rewriting higher-index data changes nothing.
      ca = 64'h1000_0000_0000_0220;
      cb = ca[NB-1:0];
      fill_data();
      @(posedge clk);
      @(negedge clk);
      held = da[5*DWA +: DWA];
      for (int w = 6; w < NA; w++) da[w*DWA +: DWA] = ~da[w*DWA +: DWA];
      for (int w = 6; w < NB; w++) db[w*DWB +: DWB] = ~db[w*DWB +: DWB];
      @(posedge clk);
      #1;
      chk("R2 A unaffected by higher data", 32'(sel_a), 32'(held));
      chk("R2 B unaffected by higher data", 32'(sel_b), 32'(db[5*DWB +: DWB]));
      @(negedge clk);
      prev_a = ref_a(ca, da);

      for (int it = 0; it < 300; it++) begin
         logic [NA-1:0] c;
         case (it % 4)
            0: c = {$urandom, $urandom};
            1: c = NA'(1) << ($urandom % NA);
            2: c = (NA'(1) << ($urandom % NA)) | (NA'(1) << ($urandom % NA));
            default: c = {$urandom, $urandom} & {$urandom, $urandom}
                         & {$urandom, $urandom};
         endcase
         apply(c, "R1");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule